// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block keeps an 8-bit count that software can read and overwrite through a simple register port. Each count event comes from one of two places. In the first, the event is a system-clock cycle on which the instruction-cycle strobe is high. In the second, the event is an edge of the external count pin, and a control bit picks which edge counts. A power-of-two prescaler can sit between the event source and the count, or a control bit can bypass it.

Each accepted event passes through a two-stage synchronizing pipeline before it increments the count. When the count rolls from FFh to 00h, a sticky overflow flag is set. The flag drives an interrupt output, and an enable input can mask that output. A write to the count register discards events for the next two instruction cycles. While the sleep input is high, all counting is frozen.

Top module: `prescaled_timer8`

## Requirements
- R1: While `rst` is high and right after it falls, `count_q` is 00h, `ovf_flag` is 0 and `irq` is 0.
- R2: When `wr_en` is high in a cycle, `count_q` equals `wr_data` in the next cycle. The write wins over any increment that falls in the same cycle, and `count_q` always shows the live count.
- R3: With `src_sel` = 0, each cycle with `cyc_en` high is one source event. Cycles with `cyc_en` low never advance the count, and the count never moves by more than one per clock.
- R4: With `src_sel` = 1, edges of `ext_pin` are the source events. When `edge_fall` = 0 only rising edges count, and when `edge_fall` = 1 only falling edges count. `cyc_en` is not a source event in this mode.
- R5: With `pre_bypass` = 0, one increment occurs for every 2^(`pre_ratio`+1) source events, so field values 0 to 7 give ratios 1:2 up to 1:256. With `pre_bypass` = 1, every source event increments the count and `pre_ratio` has no effect.
- R6: A count-register write clears the prescaler's partial count. The division restarts from zero after every write.
- R7: Source events in the write cycle, and in the two `cyc_en` strobes that follow it, are discarded. With `cyc_en` always high, a value D written in cycle W reads D in cycles W+1 to W+5, and D+1 in cycle W+6.
- R8: An accepted event increments the count at the end of the second clock after it. In counter mode, a pin edge that is present before clock edge c shows up in `count_q` four cycles later.
- R9: An increment from FFh to 00h sets `ovf_flag`. The flag stays set until a `flag_clr` cycle clears it. If an overflow happens in the same cycle as `flag_clr`, the flag is set.
- R10: `irq` is high exactly when `ovf_flag` and `irq_en` are both high. With `irq_en` = 0, the flag still sets but `irq` stays low.
- R11: While `sleep` is high, no source event is accepted and any increment still in the pipeline is dropped. An increment already due in the cycle `sleep` rises still lands. The count holds until `sleep` falls, and counting resumes three cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-cycle strobe |
| ext_pin | input | 1 | External count input |
| src_sel | input | 1 | Count source: 0 cycle strobe, 1 pin edge |
| edge_fall | input | 1 | Pin edge select: 0 rising, 1 falling |
| pre_bypass | input | 1 | 0 prescaler in path, 1 prescaler bypassed |
| pre_ratio | input | 3 | Prescale field, ratio 2^(field+1) |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Count register write strobe |
| wr_data | input | 8 | Count register write value |
| flag_clr | input | 1 | Overflow flag clear strobe |
| sleep | input | 1 | Freeze counting |
| count_q | output | 8 | Count register read value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The bench checks the count cycle by cycle after a write. A design with a one-cycle hold, or one that lets a tick already in the pipeline land after the write, reads D+1 too early. The bench checks prescaler ratios at their boundaries, from 1:2 up to 1:256. It also writes while the prescaler holds a partial count, which exposes an off-by-one divider or a prescaler that a write does not clear. Each pin edge polarity is run with a pulse train that ends high, so a design that counts both edges, or the wrong edge, ends one count off. The last group of tests puts `flag_clr` on the exact wrap cycle, masks the interrupt, and lands `sleep` while ticks are still in the pipeline, so that a clear that wins over a set, or an increment that leaks during sleep, is caught.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic {
    SRC_CYCLE = 1'b0,
    SRC_PIN   = 1'b1
  } src_e;

  localparam int unsigned DEF_CNT_W   = 8;
  localparam int unsigned DEF_PSEL_W  = 3;
  localparam int unsigned DEF_HOLD    = 2;
  localparam int unsigned DEF_SYNC    = 2;
endpackage

// File: rtl/tmr8_src_select.sv
module tmr8_src_select
  import tmr8_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cyc_en,
  input  logic ext_pin,
  input  logic src_sel,
  input  logic edge_fall,
  input  logic sleep,
  input  logic hold,
  input  logic wr_en,
  output logic evt
);
  logic pin_now;
  logic pin_old;
  logic pin_edge;
  logic raw_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_now <= 1'b0;
      pin_old <= 1'b0;
    end else begin
      pin_now <= ext_pin;
      pin_old <= pin_now;
    end
  end

  always_comb begin
    if (edge_fall) pin_edge = pin_old & ~pin_now;
    else           pin_edge = ~pin_old & pin_now;
  end

  always_comb begin
    unique case (src_e'(src_sel))
      SRC_PIN:   raw_evt = pin_edge;
      default:   raw_evt = cyc_en;
    endcase
  end

  assign evt = raw_evt & ~sleep & ~hold & ~wr_en;
endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int unsigned PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              evt,
  input  logic              bypass,
  input  logic [PSEL_W-1:0] ratio,
  output logic              tick
);
  localparam int unsigned PRE_W = 1 << PSEL_W;

  logic [PRE_W-1:0]  pre_cnt;
  logic [PRE_W-1:0]  top_val;
  logic [PSEL_W:0]   shamt;
  logic              at_top;

  assign shamt   = {1'b0, ratio} + 1'b1;
  assign top_val = ~({PRE_W{1'b1}} << shamt);
  assign at_top  = (pre_cnt == top_val);
  assign tick    = bypass ? evt : (evt & at_top);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_cnt <= '0;
    end else if (evt && !bypass) begin
      if (at_top) pre_cnt <= '0;
      else        pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr8_sync_pipe.sv
module tmr8_sync_pipe #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stg;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst || flush) stg[g] <= 1'b0;
        else              stg[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst || flush) stg[g] <= 1'b0;
        else              stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/tmr8_count_reg.sv
module tmr8_count_reg #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned HOLD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             inc,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_flag,
  output logic             hold
);
  localparam int unsigned HOLD_W = $clog2(HOLD + 1);

  logic [HOLD_W-1:0] hold_cnt;
  logic              wrap;

  assign wrap = inc & ~wr_en & (count_q == {CNT_W{1'b1}});
  assign hold = (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      hold_cnt <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_en)    count_q <= wr_data;
      else if (inc) count_q <= count_q + 1'b1;

      if (wr_en)                hold_cnt <= HOLD_W'(HOLD);
      else if (cyc_en && hold)  hold_cnt <= hold_cnt - 1'b1;

      if (wrap)          ovf_flag <= 1'b1;
      else if (flag_clr) ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/prescaled_timer8.sv
module prescaled_timer8 #(
  parameter int unsigned CNT_W  = tmr8_pkg::DEF_CNT_W,
  parameter int unsigned PSEL_W = tmr8_pkg::DEF_PSEL_W,
  parameter int unsigned HOLD   = tmr8_pkg::DEF_HOLD,
  parameter int unsigned SYNC   = tmr8_pkg::DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_en,
  input  logic              ext_pin,
  input  logic              src_sel,
  input  logic              edge_fall,
  input  logic              pre_bypass,
  input  logic [PSEL_W-1:0] pre_ratio,
  input  logic              irq_en,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              flag_clr,
  input  logic              sleep,
  output logic [CNT_W-1:0]  count_q,
  output logic              ovf_flag,
  output logic              irq
);
  logic evt;
  logic tick;
  logic inc;
  logic hold;

  tmr8_src_select u_src (
    .clk       (clk),
    .rst       (rst),
    .cyc_en    (cyc_en),
    .ext_pin   (ext_pin),
    .src_sel   (src_sel),
    .edge_fall (edge_fall),
    .sleep     (sleep),
    .hold      (hold),
    .wr_en     (wr_en),
    .evt       (evt)
  );

  tmr8_prescaler #(.PSEL_W(PSEL_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clear  (wr_en),
    .evt    (evt),
    .bypass (pre_bypass),
    .ratio  (pre_ratio),
    .tick   (tick)
  );

  tmr8_sync_pipe #(.STAGES(SYNC)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .flush (wr_en | sleep),
    .din   (tick),
    .dout  (inc)
  );

  tmr8_count_reg #(.CNT_W(CNT_W), .HOLD(HOLD)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .cyc_en   (cyc_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .inc      (inc),
    .flag_clr (flag_clr),
    .count_q  (count_q),
    .ovf_flag (ovf_flag),
    .hold     (hold)
  );

  assign irq = ovf_flag & irq_en;
endmodule

// File: rtl/prescaled_timer8_checker.sv
module prescaled_timer8_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic             flag_clr,
  input logic             sleep,
  input logic             irq_en,
  input logic [CNT_W-1:0] count_q,
  input logic             ovf_flag,
  input logic             irq
);
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (count_q == $past(wr_data)));  // R2

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !wr_en) |=> $stable(count_q));  // R7

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ((count_q == $past(count_q)) ||
                       (count_q == $past(count_q) + 1'b1)));  // R3

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    ($past(count_q) == {CNT_W{1'b1}} && !$past(wr_en) && count_q == '0)
      |-> ovf_flag);  // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !flag_clr) |=> ovf_flag);  // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!irq_en || !ovf_flag) |-> !irq);  // R10

  AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ($past(sleep) && !wr_en) |=> $stable(count_q));  // R11
endmodule

bind prescaled_timer8 prescaled_timer8_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .flag_clr (flag_clr),
  .sleep    (sleep),
  .irq_en   (irq_en),
  .count_q  (count_q),
  .ovf_flag (ovf_flag),
  .irq      (irq)
);

// File: tb/prescaled_timer8_bench.sv
module prescaled_timer8_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b0;
  logic       ext_pin = 1'b0;
  logic       src_sel = 1'b0;
  logic       edge_fall = 1'b0;
  logic       pre_bypass = 1'b1;
  logic [2:0] pre_ratio = 3'd0;
  logic       irq_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       flag_clr = 1'b0;
  logic       sleep = 1'b0;
  logic [7:0] count_q;
  logic       ovf_flag;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prescaled_timer8 u_prescaled_timer8 (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .src_sel(src_sel), .edge_fall(edge_fall), .pre_bypass(pre_bypass),
    .pre_ratio(pre_ratio), .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data),
    .flag_clr(flag_clr), .sleep(sleep), .count_q(count_q),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_val(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  // After a write: count at sample k is floor((k-5)/n) for k >= 5
  task automatic run_ratio(input int n, input string req);
    for (int k = 1; k <= 5 + 3 * n; k++) begin
      if (k == 5)             chk(req, count_q, 0);
      if (k == 5 + 3 * n - 1) chk(req, count_q, 2);
      if (k == 5 + 3 * n)     chk(req, count_q, 3);
      step();
    end
  endtask

  task automatic t_reset();
    chk("R1 count", count_q, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_write_hold();
    src_sel = 1'b0; pre_bypass = 1'b1; cyc_en = 1'b1;
    write_val(8'h10);
    repeat (10) step();
    write_val(8'h80);
    for (int k = 1; k <= 7; k++) begin
      chk((k <= 5) ? "R7 hold" : "R8 latency", count_q,
          (k <= 5) ? 8'h80 : 8'h80 + k - 5);
      if (k == 1) chk("R2 write wins", count_q, 8'h80);
      step();
    end
  endtask

  task automatic t_strobe_gate();
    int c0;
    src_sel = 1'b0; pre_bypass = 1'b1; cyc_en = 1'b1;
    write_val(8'h20);
    repeat (8) step();
    cyc_en = 1'b0;
    repeat (4) step();
    c0 = count_q;
    repeat (6) step();
    chk("R3 no strobe no count", count_q, c0);
    for (int i = 0; i < 10; i++) begin
      cyc_en = 1'b1; step();
      cyc_en = 1'b0; step(); step();
    end
    repeat (4) step();
    chk("R3 one per strobe", count_q, c0 + 10);
  endtask

  task automatic t_prescale();
    src_sel = 1'b0; cyc_en = 1'b1; pre_bypass = 1'b0;
    pre_ratio = 3'd0; write_val(8'h00); run_ratio(2, "R5 ratio 1:2");
    pre_ratio = 3'd2; write_val(8'h00); run_ratio(8, "R5 ratio 1:8");
    pre_ratio = 3'd7; write_val(8'h00); run_ratio(256, "R5 ratio 1:256");
    pre_bypass = 1'b1; pre_ratio = 3'd7;
    write_val(8'h00);
    repeat (14) step();
    chk("R5 bypass ignores ratio", count_q, 10);
  endtask

  task automatic t_pre_clear();
    src_sel = 1'b0; cyc_en = 1'b1; pre_bypass = 1'b0; pre_ratio = 3'd1;
    write_val(8'h00);
    repeat (4) step();
    write_val(8'h00);
    run_ratio(4, "R6 write clears prescaler");
  endtask

  task automatic t_counter(input logic fall);
    src_sel = 1'b1; pre_bypass = 1'b1; cyc_en = 1'b1;
    edge_fall = fall; ext_pin = 1'b0;
    write_val(8'h00);
    repeat (8) step();
    chk("R4 strobe ignored in pin mode", count_q, 0);
    for (int p = 0; p < 4; p++) begin
      ext_pin = 1'b1;
      for (int j = 1; j <= 4; j++) begin
        step();
        if (p == 0 && !fall) chk("R8 pin latency", count_q, (j < 4) ? 0 : 1);
      end
      if (p != 3) begin
        ext_pin = 1'b0;
        repeat (4) step();
      end
    end
    repeat (6) step();
    chk(fall ? "R4 falling edges" : "R4 rising edges", count_q, fall ? 3 : 4);
    ext_pin = 1'b0;
    repeat (6) step();
    src_sel = 1'b0; edge_fall = 1'b0;
  endtask

  task automatic t_overflow();
    src_sel = 1'b0; pre_bypass = 1'b1; cyc_en = 1'b1; irq_en = 1'b1;
    write_val(8'hFD);
    for (int k = 1; k < 7; k++) step();
    chk("R9 no flag before wrap", ovf_flag, 0);
    chk("R9 at FF", count_q, 8'hFF);
    step();
    chk("R9 wrap to 00", count_q, 0);
    chk("R9 flag set", ovf_flag, 1);
    chk("R10 irq enabled", irq, 1);
    repeat (5) step();
    chk("R9 flag sticky", ovf_flag, 1);
    irq_en = 1'b0;
    #1 chk("R10 irq masked", irq, 0);
    chk("R10 flag kept while masked", ovf_flag, 1);
    irq_en = 1'b1;
    write_val(8'hFD);
    for (int k = 1; k < 7; k++) step();
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    chk("R9 set wins over clear", ovf_flag, 1);
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    chk("R9 clear", ovf_flag, 0);
    chk("R10 irq low after clear", irq, 0);
    irq_en = 1'b0;
    write_val(8'hFD);
    repeat (10) step();
    chk("R10 flag sets while masked", ovf_flag, 1);
    chk("R10 irq stays low", irq, 0);
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
  endtask

  task automatic t_sleep();
    int c;
    src_sel = 1'b0; pre_bypass = 1'b1; cyc_en = 1'b1;
    write_val(8'h40);
    repeat (10) step();
    c = count_q;
    sleep = 1'b1;
    step();
    chk("R11 due increment lands", count_q, c + 1);
    repeat (10) step();
    chk("R11 frozen", count_q, c + 1);
    sleep = 1'b0;
    step(); step();
    chk("R11 still held", count_q, c + 1);
    step();
    chk("R11 resumes", count_q, c + 2);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_write_hold();
    t_strobe_gate();
    t_prescale();
    t_pre_clear();
    t_counter(1'b0);
    t_counter(1'b1);
    t_overflow();
    t_sleep();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule